// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Pairwise LRU

This block holds four recently fetched instruction words, each tagged with the effective fetch address, so that the fetch stage can look up an instruction before it goes to memory. A request carries an address, a flag that tells a real fetch apart from a speculative prefetch, and a supervisor flag. A supervisor fetch is unmapped. A user fetch is translated through a page-frame lookup that the block drives with the page number and reads back in the same cycle. On a hit the stored word is returned. On a miss the least recently used entry is retagged and refilled. The refill comes from the memory read port, or from the switch-register port when the physical address is below 8.

Recency is held as six pairwise "newer-than" bits. Only real fetches move an entry to most recent, so speculative prefetches can fill the buffer without disturbing the ordering. Real fetches are also checked. A fetch from address 0 and a user fetch from a page mapped to frame 0 are trapped before any lookup. A returned word whose kind field is not the instruction kind is flagged. The buffer can be switched off. It then passes real fetches straight to the read ports and answers speculative requests with zero. Results appear one clock after the request.

Top module: `instr_prefetch_buf`

## Requirements
- R1: After reset no entry is valid, no response is pending, and the recency bits rank entry 3 newest down to entry 0 oldest, so entry 0 is the first victim.
- R2: A request whose effective address {supervisor flag, address} matches a valid tag returns that entry's word with neither read port enabled.
- R3: Only a real fetch (hit or fill) makes its entry the most recent; a speculative hit or fill leaves the recency bits unchanged, so back-to-back speculative misses reuse the same victim.
- R4: On a miss with the buffer enabled, the entry that every other entry is newer than is retagged and refilled from the read port.
- R5: A supervisor fetch uses the 15-bit address as the physical address and is tagged with bit 15 set, so it never matches a user fetch of the same address.
- R6: A user fetch drives address bits [14:10] as the page number and reads from the physical address {frame, address[9:0]}.
- R7: A real user fetch (address not 0) whose page maps to frame 0 returns a zero word with the protection fault set and reads nothing and changes no state.
- R8: A real fetch from address 0, in either mode, returns a zero word with the check fault set, no protection fault, no read and no state change.
- R9: A physical address below 8 is read through the switch-register port with index equal to its low 3 bits; memory is never read for it, and the two ports are never enabled together.
- R10: With the buffer disabled, a speculative request returns 0 with no read, and a real fetch reads the port directly and leaves the buffer contents and recency untouched.
- R11: Stored words carry a 2-bit kind field above the data bits; value 2'b10 marks an instruction. A real fetch that is not otherwise trapped and returns a word of any other kind raises the check fault when its effective address is 8 or more, while still returning the word.
- R12: The response valid, word and faults appear in the cycle after the request and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Buffer enable |
| req_valid | input | 1 | Request strobe |
| req_actual | input | 1 | 1 for a real fetch, 0 for a speculative prefetch |
| req_super | input | 1 | Supervisor-mode fetch (unmapped) |
| req_addr | input | AW (15) | Fetch address |
| pf_page | output | AW-10 (5) | Page number presented to the frame lookup |
| pf_frame | input | FW (5) | Frame number returned for pf_page |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | FW+10 (15) | Memory physical address |
| mem_rdata | input | DW+2 (50) | Memory word, kind field on top |
| sw_re | output | 1 | Switch-register read enable |
| sw_idx | output | 3 | Switch-register index |
| sw_rdata | input | DW+2 (50) | Switch-register word, kind field on top |
| rsp_valid | output | 1 | Response strobe |
| rsp_word | output | DW (48) | Returned instruction bits |
| flt_iprot | output | 1 | Instruction protection fault |
| flt_icheck | output | 1 | Instruction check fault |

## Verification
The assertions check on every cycle the properties that hold whatever the traffic: there is exactly one victim, speculative requests and trapped fetches leave the recency bits alone, address 0 traps, the two read ports are never enabled together, a disabled speculative request stays quiet, and responses come one cycle late. Which entry is evicted after a given mix of real and speculative fetches shows up only as a read that a hit would have avoided. Likewise, whether a translated address, a switch index or a kind-fault exemption is right can be shown only by the bench. It does this by replaying long mixed request sequences against its own timestamp model of recency and comparing every read strobe, address and response.

// File: rtl/instr_prefetch_buf.sv
module instr_prefetch_buf #(
  parameter int DW = 48,
  parameter int AW = 15,
  parameter int FW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_en,
  input  logic              req_valid,
  input  logic              req_actual,
  input  logic              req_super,
  input  logic [AW-1:0]     req_addr,
  output logic [AW-11:0]    pf_page,
  input  logic [FW-1:0]     pf_frame,
  output logic              mem_re,
  output logic [FW+9:0]     mem_addr,
  input  logic [DW+1:0]     mem_rdata,
  output logic              sw_re,
  output logic [2:0]        sw_idx,
  input  logic [DW+1:0]     sw_rdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_word,
  output logic              flt_iprot,
  output logic              flt_icheck
);
  localparam int NE  = 4;
  localparam int TW  = AW + 1;
  localparam int PAW = FW + 10;
  localparam int WW  = DW + 2;
  localparam logic [1:0] KIND_INSN = 2'b10;

  logic [TW-1:0]  tag   [NE];
  logic [WW-1:0]  store [NE];
  logic [NE-1:0]  vld;
  logic [5:0]     lru;

  function automatic logic [5:0] win_m(input logic [1:0] i);
    case (i)
      2'd0:    win_m = 6'b000111;
      2'd1:    win_m = 6'b011000;
      2'd2:    win_m = 6'b100000;
      default: win_m = 6'b000000;
    endcase
  endfunction

  function automatic logic [5:0] lose_m(input logic [1:0] i);
    case (i)
      2'd0:    lose_m = 6'b000000;
      2'd1:    lose_m = 6'b000001;
      2'd2:    lose_m = 6'b001010;
      default: lose_m = 6'b110100;
    endcase
  endfunction

  logic [TW-1:0]  eff;
  logic [PAW-1:0] phys;
  logic           is_sw, f_zero, f_prot, blocked, need_read, kind_bad;
  logic [NE-1:0]  hit, victim;
  logic           hit_any;
  logic [1:0]     hit_idx, vic_idx, wr_idx;
  logic [WW-1:0]  fetched, sel_word;

  assign eff     = {req_super, req_addr};
  assign pf_page = req_addr[AW-1:10];
  assign phys    = req_super ? PAW'(req_addr) : {pf_frame, req_addr[9:0]};
  assign is_sw   = (phys < PAW'(8));
  assign f_zero  = req_actual && (req_addr == '0);
  assign f_prot  = req_actual && !req_super && (pf_frame == '0) && !f_zero;
  assign blocked = f_zero || f_prot;

  generate
    for (genvar g = 0; g < NE; g++) begin : g_cmp
      assign hit[g]    = vld[g] && (tag[g] == eff);
      assign victim[g] = ((lru & win_m(2'(g))) == 6'b0) &&
                         ((lru & lose_m(2'(g))) == lose_m(2'(g)));
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    vic_idx = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hit[i])    hit_idx = 2'(i);
      if (victim[i]) vic_idx = 2'(i);
    end
  end

  assign hit_any   = |hit;
  assign wr_idx    = hit_any ? hit_idx : vic_idx;
  assign need_read = req_valid && !blocked && (buf_en ? !hit_any : req_actual);
  assign mem_re    = need_read && !is_sw;
  assign sw_re     = need_read && is_sw;
  assign mem_addr  = phys;
  assign sw_idx    = phys[2:0];
  assign fetched   = is_sw ? sw_rdata : mem_rdata;

  always_comb begin
    if (blocked)               sel_word = '0;
    else if (buf_en && hit_any) sel_word = store[hit_idx];
    else if (need_read)        sel_word = fetched;
    else                       sel_word = '0;
  end

  assign kind_bad = req_actual && !blocked && (sel_word[WW-1:DW] != KIND_INSN) &&
                    (eff >= TW'(8));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      lru <= '0;
      for (int i = 0; i < NE; i++) begin
        tag[i]   <= '0;
        store[i] <= '0;
      end
    end else if (req_valid && !blocked && buf_en) begin
      if (!hit_any) begin
        vld[vic_idx]   <= 1'b1;
        tag[vic_idx]   <= eff;
        store[vic_idx] <= fetched;
      end
      if (req_actual)
        lru <= (lru & ~lose_m(wr_idx)) | win_m(wr_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_word   <= '0;
      flt_iprot  <= 1'b0;
      flt_icheck <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_word   <= req_valid ? sel_word[DW-1:0] : '0;
      flt_iprot  <= req_valid && f_prot;
      flt_icheck <= req_valid && (f_zero || kind_bad);
    end
  end

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(victim) == 1); // R4
  AST_SPEC_KEEPS_LRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_actual |=> $stable(lru)); // R3
  AST_ADDR0_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_actual && req_addr == '0 |=> rsp_valid && flt_icheck && !flt_iprot && $stable(lru) && $stable(vld)); // R8
  AST_PROT_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_actual && !req_super && pf_frame == '0 && req_addr != '0 |=> flt_iprot && $stable(lru) && $stable(vld)); // R7
  AST_PORTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && sw_re)); // R9
  AST_DIS_SPEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !buf_en && !req_actual |-> !mem_re && !sw_re); // R10
  AST_DIS_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !buf_en |=> $stable(lru) && $stable(vld)); // R10
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R12
endmodule

// File: tb/test_instr_prefetch_buf.sv
`timescale 1ns/1ps
module test_instr_prefetch_buf;
  localparam int DW = 48, AW = 15, FW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic buf_en = 1'b1, req_valid = 1'b0, req_actual = 1'b0, req_super = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [AW-11:0] pf_page;
  logic [FW-1:0] pf_frame;
  logic mem_re, sw_re, rsp_valid, flt_iprot, flt_icheck;
  logic [FW+9:0] mem_addr;
  logic [DW+1:0] mem_rdata, sw_rdata;
  logic [2:0] sw_idx;
  logic [DW-1:0] rsp_word;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [FW-1:0] frm(input logic [4:0] pg);
    frm = (pg == 5'd2) ? '0 : FW'(pg + 5'd3);
  endfunction
  function automatic logic [DW+1:0] memw(input logic [14:0] pa);
    memw = {(pa[9:3] == 7'd0) ? 2'b01 : 2'b10, pa, ~pa, 18'h2A5A5};
  endfunction
  function automatic logic [DW+1:0] swd(input logic [2:0] i);
    swd = {(i == 3'd3) ? 2'b01 : 2'b10, 45'h1234_5678_9AB, i};
  endfunction

  assign pf_frame  = frm(pf_page);
  assign mem_rdata = memw(mem_addr);
  assign sw_rdata  = swd(sw_idx);

  instr_prefetch_buf #(.DW(DW), .AW(AW), .FW(FW)) i_instr_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .req_valid(req_valid),
    .req_actual(req_actual), .req_super(req_super), .req_addr(req_addr),
    .pf_page(pf_page), .pf_frame(pf_frame), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .sw_re(sw_re), .sw_idx(sw_idx), .sw_rdata(sw_rdata),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .flt_iprot(flt_iprot),
    .flt_icheck(flt_icheck));

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  logic [15:0] rtag [4];
  bit          rval [4];
  int          stamp [4];
  int          now;

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      rval[i] = 0; rtag[i] = '0; stamp[i] = i;
    end
    now = 4;
  endtask

  task automatic do_req(input logic sup, input logic [14:0] addr, input logic act,
                        input logic en, input string lbl);
    logic [15:0] eff; logic [14:0] pa; logic [FW-1:0] fr; logic [DW+1:0] w;
    bit issw, fz, fp, blk, hit, rd, kbad; int h, v;
    eff = {sup, addr};
    fr  = frm(addr[14:10]);
    pa  = sup ? addr : {fr, addr[9:0]};
    issw = pa < 15'd8;
    w   = issw ? swd(pa[2:0]) : memw(pa);
    fz  = act && addr == '0;
    fp  = act && !sup && fr == '0 && !fz;
    blk = fz || fp;
    hit = 0; h = 0;
    for (int i = 0; i < 4; i++) if (rval[i] && rtag[i] == eff && !hit) begin hit = 1; h = i; end
    rd  = !blk && (en ? !hit : act);
    kbad = act && !blk && w[DW+1:DW] != 2'b10 && eff >= 16'd8;
    req_super = sup; req_addr = addr; req_actual = act; buf_en = en; req_valid = 1'b1;
    #1;
    chk(mem_re == (rd && !issw), lbl, 64'(mem_re), 64'(rd && !issw));
    chk(sw_re == (rd && issw), issw ? "R9" : lbl, 64'(sw_re), 64'(rd && issw));
    if (rd && !issw) chk(mem_addr == pa, sup ? "R5" : "R6", 64'(mem_addr), 64'(pa));
    if (rd && issw)  chk(sw_idx == pa[2:0], "R9", 64'(sw_idx), 64'(pa[2:0]));
    if (!blk && en) begin
      if (hit) v = h;
      else begin
        v = 0;
        for (int i = 1; i < 4; i++) if (stamp[i] < stamp[v]) v = i;
        rval[v] = 1; rtag[v] = eff;
      end
      if (act) begin stamp[v] = now; now++; end
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R12", 64'(rsp_valid), 64'd1);
    chk(rsp_word == ((blk || (!en && !act)) ? '0 : w[DW-1:0]),
        blk ? (fz ? "R8" : "R7") : (!en ? "R10" : (sup ? "R5" : "R6")),
        64'(rsp_word), 64'((blk || (!en && !act)) ? '0 : w[DW-1:0]));
    chk(flt_iprot == fp, "R7", 64'(flt_iprot), 64'(fp));
    chk(flt_icheck == (fz || kbad), fz ? "R8" : "R11", 64'(flt_icheck), 64'(fz || kbad));
    req_valid = 1'b0;
  endtask

  logic [15:0] pool [14];
  initial begin
    pool[0] = 16'h8003;  pool[1] = 16'h8C05;  pool[2] = 16'h0005;  pool[3] = 16'h0800;
    pool[4] = 16'h0000;  pool[5] = 16'h8000;  pool[6] = 16'h1234;  pool[7] = 16'h2345;
    pool[8] = 16'h9234;  pool[9] = 16'hFFFF;  pool[10] = 16'h7C10; pool[11] = 16'h0410;
    pool[12] = 16'h0803; pool[13] = 16'h1234;
  end

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && flt_icheck == 1'b0 && flt_iprot == 1'b0, "R1",
        64'({rsp_valid, flt_icheck, flt_iprot}), 64'd0);
    do_req(0, 15'h1000, 1, 1, "R1");
    do_req(0, 15'h1001, 1, 1, "R4");
    do_req(0, 15'h1002, 1, 1, "R4");
    do_req(0, 15'h1003, 1, 1, "R4");
    do_req(0, 15'h1000, 1, 1, "R2");
    do_req(0, 15'h2000, 0, 1, "R3");
    do_req(0, 15'h2001, 0, 1, "R3");
    do_req(0, 15'h1002, 1, 1, "R2");
    do_req(0, 15'h2000, 0, 1, "R3");
    do_req(1, 15'h1000, 1, 1, "R5");
    do_req(0, 15'h1000, 0, 1, "R2");
    do_req(0, 15'h0000, 1, 1, "R8");
    do_req(1, 15'h0000, 1, 1, "R8");
    do_req(0, 15'h0845, 1, 1, "R7");
    do_req(0, 15'h0803, 0, 1, "R9");
    do_req(1, 15'h0003, 1, 1, "R9");
    do_req(0, 15'h0005, 1, 1, "R11");
    do_req(1, 15'h0C05, 1, 1, "R11");
    do_req(0, 15'h3333, 0, 0, "R10");
    do_req(0, 15'h3333, 1, 0, "R10");
    do_req(0, 15'h3333, 0, 1, "R10");
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] e;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      e = pool[lf[3:0] % 14];
      if (lf[7:4] == 4'd9) e[7:0] = lf[15:8];
      do_req(e[15], e[14:0], lf[8] | lf[9], lf[12:10] != 3'd0, lf[8] | lf[9] ? "R4" : "R3");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule